// File: doc/BRIEF.md
# Multi-View Floating-Point Register File

This block holds 64 words of 32 bits. It gives four access views onto the same storage, with a read port and a write port for each view. The views are single words, double-width pairs, four-word vectors and sixteen-word matrices. The block only moves raw bits. It does no arithmetic, rounding or format conversion. The block's own work is index decoding: which words each view reaches, and in what order.

A pair access at an even index `n` treats word `n` as the high half and word `n+1` as the low half. A pair index that is odd, or is the last word, is refused and raises a flag. Vector and matrix indices arrive at full register-index width. The block drops the upper bits of these indices, then scales the result to a base word. Reads are combinational from storage, and writes take effect at the clock edge. When several write ports hit the same word in one cycle, a fixed priority decides which value is kept.

Top module: `fp_view_regfile`

## Requirements
- R1: While `rst_ni` is low, all 64 words clear to zero, and every read view then returns zero.
- R2: A single-word write stores `s_wr_data_i` into word `s_wr_idx_i` at the clock edge. `s_rd_data_o` always shows word `s_rd_idx_i` combinationally, and no other word changes.
- R3: For an even `d_rd_idx_i` below 63, `d_rd_data_o[63:32]` is word `n` and `d_rd_data_o[31:0]` is word `n+1`.
- R4: A legal pair write updates two words in the same clock edge. `d_wr_data_i[63:32]` goes to word `n` and `d_wr_data_i[31:0]` goes to word `n+1`.
- R5: A pair index that is odd, or equal to 63, is illegal. For writes, `d_wr_bad_o` is high while the write is enabled and no word changes. For reads, `d_rd_bad_o` is high and `d_rd_data_o` is zero.
- R6: The vector view keeps only bits 3:0 of its index, and the base word is that value times 4. Element `k` (0..3) is word `base+k`, in bits `[32k+31:32k]` of the vector data. This layout applies to both reads and writes.
- R7: The matrix view keeps only bits 1:0 of its index, and the base word is that value times 16. Element `k` (0..15) is word `base+k`, in bits `[32k+31:32k]` of the matrix data. This layout applies to both reads and writes.
- R8: When several views write the same word in one cycle, the kept value is chosen by this priority: single first, then pair, then vector, then matrix. Words that only one view writes take that view's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_rd_idx_i | input | 6 | Single-view read index |
| s_rd_data_o | output | 32 | Single-view read data |
| d_rd_idx_i | input | 6 | Pair-view read index |
| d_rd_data_o | output | 64 | Pair-view read data, word n high |
| d_rd_bad_o | output | 1 | Pair read index illegal |
| v_rd_idx_i | input | 6 | Vector read index, low 4 bits used |
| v_rd_data_o | output | 128 | Vector read data, element 0 lowest |
| m_rd_idx_i | input | 6 | Matrix read index, low 2 bits used |
| m_rd_data_o | output | 512 | Matrix read data, element 0 lowest |
| s_wr_en_i | input | 1 | Single-view write enable |
| s_wr_idx_i | input | 6 | Single-view write index |
| s_wr_data_i | input | 32 | Single-view write data |
| d_wr_en_i | input | 1 | Pair-view write enable |
| d_wr_idx_i | input | 6 | Pair-view write index |
| d_wr_data_i | input | 64 | Pair-view write data |
| d_wr_bad_o | output | 1 | Pair write refused (illegal index) |
| v_wr_en_i | input | 1 | Vector write enable |
| v_wr_idx_i | input | 6 | Vector write index, low 4 bits used |
| v_wr_data_i | input | 128 | Vector write data |
| m_wr_en_i | input | 1 | Matrix write enable |
| m_wr_idx_i | input | 6 | Matrix write index, low 2 bits used |
| m_wr_data_i | input | 512 | Matrix write data |

## Verification
The bench writes distinct values through one view and reads them back through the other views. This shows whether every view resolves to the same physical words, in the stated order.

- Pair writes with different high and low halves show whether the halves are swapped.
- Vector and matrix indices carry set upper bits, so the bench can see whether those bits are masked off or leak into the base.
- Odd pair indices and index 63 are followed by a full matrix readback, which exposes any partial write.
- One cycle drives all four write ports onto overlapping words, which separates the four priority orders.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
  localparam int unsigned FPV_NW = 64;  // words in storage
  localparam int unsigned FPV_W  = 32;  // bits per word
  localparam int unsigned FPV_VL = 4;   // words per vector
  localparam int unsigned FPV_ML = 16;  // words per matrix
endpackage

// File: rtl/fpv_index_map.sv
module fpv_index_map #(
  parameter int unsigned NW     = 64,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned VBLK_W = 4,
  parameter int unsigned MBLK_W = 2
) (
  input  logic [IDX_W-1:0]  d_idx_i,
  input  logic [IDX_W-1:0]  v_idx_i,
  input  logic [IDX_W-1:0]  m_idx_i,
  output logic              d_ok_o,
  output logic [VBLK_W-1:0] v_blk_o,
  output logic [MBLK_W-1:0] m_blk_o
);
  // pair needs an even index with a following word
  assign d_ok_o  = !d_idx_i[0] && (d_idx_i != IDX_W'(NW-1));
  assign v_blk_o = v_idx_i[VBLK_W-1:0];
  assign m_blk_o = m_idx_i[MBLK_W-1:0];
endmodule

// File: rtl/fpv_word_cell.sv
module fpv_word_cell #(
  parameter int unsigned W      = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned VL     = 4,
  parameter int unsigned ML     = 16,
  parameter int unsigned VBLK_W = 4,
  parameter int unsigned MBLK_W = 2,
  parameter int unsigned WIDX   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_en_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  logic [W-1:0]      s_data_i,
  input  logic              d_en_i,
  input  logic [IDX_W-1:0]  d_idx_i,
  input  logic [2*W-1:0]    d_data_i,
  input  logic              v_en_i,
  input  logic [VBLK_W-1:0] v_blk_i,
  input  logic [VL*W-1:0]   v_data_i,
  input  logic              m_en_i,
  input  logic [MBLK_W-1:0] m_blk_i,
  input  logic [ML*W-1:0]   m_data_i,
  output logic [W-1:0]      q_o
);
  localparam int unsigned VBLK = WIDX / VL;
  localparam int unsigned VOFF = WIDX % VL;
  localparam int unsigned MBLK = WIDX / ML;
  localparam int unsigned MOFF = WIDX % ML;
  localparam int unsigned LSRC = (WIDX > 0) ? WIDX - 1 : 0;
  localparam bit          HAS_LO = (WIDX > 0);

  logic [W-1:0] nxt;
  logic m_hit, v_hit, d_hi, d_lo, s_hit;

  assign m_hit = m_en_i && (m_blk_i == MBLK_W'(MBLK));
  assign v_hit = v_en_i && (v_blk_i == VBLK_W'(VBLK));
  assign d_hi  = d_en_i && (d_idx_i == IDX_W'(WIDX));
  assign d_lo  = HAS_LO && d_en_i && (d_idx_i == IDX_W'(LSRC));
  assign s_hit = s_en_i && (s_idx_i == IDX_W'(WIDX));

  // later assignments win: single > pair > vector > matrix
  always_comb begin
    nxt = q_o;
    if (m_hit) nxt = m_data_i[MOFF*W +: W];
    if (v_hit) nxt = v_data_i[VOFF*W +: W];
    if (d_hi)  nxt = d_data_i[2*W-1:W];
    if (d_lo)  nxt = d_data_i[W-1:0];
    if (s_hit) nxt = s_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/fpv_read_views.sv
module fpv_read_views #(
  parameter int unsigned NW     = 64,
  parameter int unsigned W      = 32,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned VL     = 4,
  parameter int unsigned ML     = 16,
  parameter int unsigned VBLK_W = 4,
  parameter int unsigned MBLK_W = 2
) (
  input  logic [NW*W-1:0]   words_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  logic [IDX_W-1:0]  d_idx_i,
  input  logic              d_ok_i,
  input  logic [VBLK_W-1:0] v_blk_i,
  input  logic [MBLK_W-1:0] m_blk_i,
  output logic [W-1:0]      s_data_o,
  output logic [2*W-1:0]    d_data_o,
  output logic [VL*W-1:0]   v_data_o,
  output logic [ML*W-1:0]   m_data_o
);
  logic [W-1:0] d_hi, d_lo;
  int unsigned  d_lo_idx;

  assign d_lo_idx = d_ok_i ? int'(d_idx_i) + 1 : 0;
  assign s_data_o = words_i[int'(s_idx_i)*W +: W];
  assign d_hi     = words_i[int'(d_idx_i)*W +: W];
  assign d_lo     = words_i[d_lo_idx*W +: W];
  assign d_data_o = d_ok_i ? {d_hi, d_lo} : '0;
  assign v_data_o = words_i[int'(v_blk_i)*VL*W +: VL*W];
  assign m_data_o = words_i[int'(m_blk_i)*ML*W +: ML*W];
endmodule

// File: rtl/fp_view_regfile.sv
module fp_view_regfile import fpv_pkg::*; #(
  parameter  int unsigned NW     = FPV_NW,
  parameter  int unsigned W      = FPV_W,
  parameter  int unsigned VL     = FPV_VL,
  parameter  int unsigned ML     = FPV_ML,
  localparam int unsigned IDX_W  = $clog2(NW),
  localparam int unsigned VBLK_W = $clog2(NW / VL),
  localparam int unsigned MBLK_W = $clog2(NW / ML)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  s_rd_idx_i,
  output logic [W-1:0]      s_rd_data_o,
  input  logic [IDX_W-1:0]  d_rd_idx_i,
  output logic [2*W-1:0]    d_rd_data_o,
  output logic              d_rd_bad_o,
  input  logic [IDX_W-1:0]  v_rd_idx_i,
  output logic [VL*W-1:0]   v_rd_data_o,
  input  logic [IDX_W-1:0]  m_rd_idx_i,
  output logic [ML*W-1:0]   m_rd_data_o,
  input  logic              s_wr_en_i,
  input  logic [IDX_W-1:0]  s_wr_idx_i,
  input  logic [W-1:0]      s_wr_data_i,
  input  logic              d_wr_en_i,
  input  logic [IDX_W-1:0]  d_wr_idx_i,
  input  logic [2*W-1:0]    d_wr_data_i,
  output logic              d_wr_bad_o,
  input  logic              v_wr_en_i,
  input  logic [IDX_W-1:0]  v_wr_idx_i,
  input  logic [VL*W-1:0]   v_wr_data_i,
  input  logic              m_wr_en_i,
  input  logic [IDX_W-1:0]  m_wr_idx_i,
  input  logic [ML*W-1:0]   m_wr_data_i
);
  logic [NW*W-1:0]   words;
  logic              rd_ok, wr_ok, d_wr_go;
  logic [VBLK_W-1:0] rd_vblk, wr_vblk;
  logic [MBLK_W-1:0] rd_mblk, wr_mblk;

  fpv_index_map #(.NW(NW), .IDX_W(IDX_W), .VBLK_W(VBLK_W), .MBLK_W(MBLK_W)) u_rd_map (
    .d_idx_i(d_rd_idx_i), .v_idx_i(v_rd_idx_i), .m_idx_i(m_rd_idx_i),
    .d_ok_o(rd_ok), .v_blk_o(rd_vblk), .m_blk_o(rd_mblk));

  fpv_index_map #(.NW(NW), .IDX_W(IDX_W), .VBLK_W(VBLK_W), .MBLK_W(MBLK_W)) u_wr_map (
    .d_idx_i(d_wr_idx_i), .v_idx_i(v_wr_idx_i), .m_idx_i(m_wr_idx_i),
    .d_ok_o(wr_ok), .v_blk_o(wr_vblk), .m_blk_o(wr_mblk));

  assign d_wr_go    = d_wr_en_i && wr_ok;
  assign d_wr_bad_o = d_wr_en_i && !wr_ok;
  assign d_rd_bad_o = !rd_ok;

  for (genvar i = 0; i < NW; i++) begin : g_word
    fpv_word_cell #(
      .W(W), .IDX_W(IDX_W), .VL(VL), .ML(ML),
      .VBLK_W(VBLK_W), .MBLK_W(MBLK_W), .WIDX(i)
    ) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .s_en_i(s_wr_en_i), .s_idx_i(s_wr_idx_i), .s_data_i(s_wr_data_i),
      .d_en_i(d_wr_go), .d_idx_i(d_wr_idx_i), .d_data_i(d_wr_data_i),
      .v_en_i(v_wr_en_i), .v_blk_i(wr_vblk), .v_data_i(v_wr_data_i),
      .m_en_i(m_wr_en_i), .m_blk_i(wr_mblk), .m_data_i(m_wr_data_i),
      .q_o(words[i*W +: W]));
  end

  fpv_read_views #(
    .NW(NW), .W(W), .IDX_W(IDX_W), .VL(VL), .ML(ML),
    .VBLK_W(VBLK_W), .MBLK_W(MBLK_W)
  ) u_rd (
    .words_i(words), .s_idx_i(s_rd_idx_i), .d_idx_i(d_rd_idx_i), .d_ok_i(rd_ok),
    .v_blk_i(rd_vblk), .m_blk_i(rd_mblk),
    .s_data_o(s_rd_data_o), .d_data_o(d_rd_data_o),
    .v_data_o(v_rd_data_o), .m_data_o(m_rd_data_o));
endmodule

// File: rtl/fpv_regfile_chk.sv
module fpv_regfile_chk #(
  parameter int unsigned NW     = 64,
  parameter int unsigned W      = 32,
  parameter int unsigned VL     = 4,
  parameter int unsigned ML     = 16,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned VBLK_W = 4,
  parameter int unsigned MBLK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NW*W-1:0]   words_i,
  input logic [IDX_W-1:0]  s_wr_idx_i,
  input logic [W-1:0]      s_wr_data_i,
  input logic              s_wr_en_i,
  input logic              d_wr_en_i,
  input logic [IDX_W-1:0]  d_wr_idx_i,
  input logic [2*W-1:0]    d_wr_data_i,
  input logic              d_wr_bad_o,
  input logic              v_wr_en_i,
  input logic              m_wr_en_i,
  input logic [IDX_W-1:0]  d_rd_idx_i,
  input logic [2*W-1:0]    d_rd_data_o,
  input logic              d_rd_bad_o,
  input logic [IDX_W-1:0]  v_rd_idx_i,
  input logic [VL*W-1:0]   v_rd_data_o,
  input logic [IDX_W-1:0]  m_rd_idx_i,
  input logic [ML*W-1:0]   m_rd_data_o
);
  logic [W-1:0]     w_a [NW];
  logic [IDX_W-1:0] d_wr_nxt, d_rd_nxt, v_base, m_top;
  logic             s_hits_pair;

  for (genvar i = 0; i < NW; i++) begin : g_unpack
    assign w_a[i] = words_i[i*W +: W];
  end

  assign d_wr_nxt    = d_wr_idx_i + 1'b1;
  assign d_rd_nxt    = d_rd_idx_i + 1'b1;
  assign v_base      = IDX_W'(v_rd_idx_i[VBLK_W-1:0]) * IDX_W'(VL);
  assign m_top       = IDX_W'(m_rd_idx_i[MBLK_W-1:0]) * IDX_W'(ML) + IDX_W'(ML - 1);
  assign s_hits_pair = s_wr_en_i && (s_wr_idx_i == d_wr_idx_i || s_wr_idx_i == d_wr_nxt);

  // R2
  s_wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_wr_en_i |=> w_a[$past(s_wr_idx_i)] == $past(s_wr_data_i));

  // R4
  d_wr_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_wr_en_i && !d_wr_bad_o && !s_hits_pair) |=>
      {w_a[$past(d_wr_idx_i)], w_a[$past(d_wr_nxt)]} == $past(d_wr_data_i));

  // R5
  d_wr_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_wr_en_i && d_wr_bad_o && !s_wr_en_i && !v_wr_en_i && !m_wr_en_i) |=> $stable(words_i));

  // R5
  d_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_rd_bad_o |-> d_rd_data_o == '0);

  // R3
  d_rd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d_rd_bad_o |-> d_rd_data_o == {w_a[d_rd_idx_i], w_a[d_rd_nxt]});

  // R6
  v_rd_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_rd_data_o[W-1:0] == w_a[v_base]);

  // R7
  m_rd_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rd_data_o[ML*W-1 -: W] == w_a[m_top]);
endmodule

bind fp_view_regfile fpv_regfile_chk #(
  .NW(NW), .W(W), .VL(VL), .ML(ML), .IDX_W(IDX_W), .VBLK_W(VBLK_W), .MBLK_W(MBLK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .words_i(words),
  .s_wr_idx_i(s_wr_idx_i), .s_wr_data_i(s_wr_data_i), .s_wr_en_i(s_wr_en_i),
  .d_wr_en_i(d_wr_en_i), .d_wr_idx_i(d_wr_idx_i), .d_wr_data_i(d_wr_data_i),
  .d_wr_bad_o(d_wr_bad_o), .v_wr_en_i(v_wr_en_i), .m_wr_en_i(m_wr_en_i),
  .d_rd_idx_i(d_rd_idx_i), .d_rd_data_o(d_rd_data_o), .d_rd_bad_o(d_rd_bad_o),
  .v_rd_idx_i(v_rd_idx_i), .v_rd_data_o(v_rd_data_o),
  .m_rd_idx_i(m_rd_idx_i), .m_rd_data_o(m_rd_data_o)
);

// File: tb/fp_view_regfile_tb.sv
module fp_view_regfile_tb;
  localparam int NW = 64, W = 32, VL = 4, ML = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]    s_rd_idx = '0, d_rd_idx = '0, v_rd_idx = '0, m_rd_idx = '0;
  logic [31:0]   s_rd_data;
  logic [63:0]   d_rd_data;
  logic          d_rd_bad, d_wr_bad;
  logic [127:0]  v_rd_data;
  logic [511:0]  m_rd_data;
  logic          s_we = 1'b0, d_we = 1'b0, v_we = 1'b0, m_we = 1'b0;
  logic [5:0]    s_wi = '0, d_wi = '0, v_wi = '0, m_wi = '0;
  logic [31:0]   s_wd = '0;
  logic [63:0]   d_wd = '0;
  logic [127:0]  v_wd = '0;
  logic [511:0]  m_wd = '0;

  fp_view_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_rd_idx_i(s_rd_idx), .s_rd_data_o(s_rd_data),
    .d_rd_idx_i(d_rd_idx), .d_rd_data_o(d_rd_data), .d_rd_bad_o(d_rd_bad),
    .v_rd_idx_i(v_rd_idx), .v_rd_data_o(v_rd_data),
    .m_rd_idx_i(m_rd_idx), .m_rd_data_o(m_rd_data),
    .s_wr_en_i(s_we), .s_wr_idx_i(s_wi), .s_wr_data_i(s_wd),
    .d_wr_en_i(d_we), .d_wr_idx_i(d_wi), .d_wr_data_i(d_wd), .d_wr_bad_o(d_wr_bad),
    .v_wr_en_i(v_we), .v_wr_idx_i(v_wi), .v_wr_data_i(v_wd),
    .m_wr_en_i(m_we), .m_wr_idx_i(m_wi), .m_wr_data_i(m_wd));

  typedef struct {
    int           kind;  // 0 single, 1 pair, 2 vector, 3 matrix, 4 rd_bad, 5 wr_bad
    logic [511:0] exp;
    string        req;
  } item_t;

  item_t       sb[$];
  event        chk_ev;
  int          total = 0, fails = 0;
  bit          done = 1'b0;
  logic [31:0] mdl [NW];

  function automatic logic [511:0] actual(int kind);
    case (kind)
      0: return 512'(s_rd_data);
      1: return 512'(d_rd_data);
      2: return 512'(v_rd_data);
      3: return m_rd_data;
      4: return 512'(d_rd_bad);
      default: return 512'(d_wr_bad);
    endcase
  endfunction

  // monitor
  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (actual(it.kind) !== it.exp) begin
        fails++;
        $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, actual(it.kind), it.exp);
      end
    end
  end

  task automatic push(int kind, logic [511:0] e, string r);
    item_t it;
    it.kind = kind; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic fire();
    #1 -> chk_ev;
    #1;
  endtask

  function automatic logic [511:0] e_dbl(int n);
    if ((n % 2) != 0 || n == NW - 1) return '0;
    return 512'({mdl[n], mdl[n+1]});
  endfunction

  function automatic logic [511:0] e_vec(int idx);
    logic [511:0] r = '0;
    int base = (idx & 15) * VL;
    for (int k = 0; k < VL; k++) r[k*W +: W] = mdl[base+k];
    return r;
  endfunction

  function automatic logic [511:0] e_mtx(int idx);
    logic [511:0] r = '0;
    int base = (idx & 3) * ML;
    for (int k = 0; k < ML; k++) r[k*W +: W] = mdl[base+k];
    return r;
  endfunction

  task automatic rd_s(int idx, string r);
    s_rd_idx = 6'(idx); push(0, 512'(mdl[idx]), r); fire();
  endtask
  task automatic rd_d(int idx, string r);
    d_rd_idx = 6'(idx); push(1, e_dbl(idx), r);
    push(4, 512'(((idx % 2) != 0 || idx == NW - 1) ? 1 : 0), r); fire();
  endtask
  task automatic rd_v(int idx, string r);
    v_rd_idx = 6'(idx); push(2, e_vec(idx), r); fire();
  endtask
  task automatic rd_m(int idx, string r);
    m_rd_idx = 6'(idx); push(3, e_mtx(idx), r); fire();
  endtask

  // apply model with the stated priority, then clock the design
  task automatic commit();
    if (m_we) for (int k = 0; k < ML; k++) mdl[(m_wi & 3)*ML + k] = m_wd[k*W +: W];
    if (v_we) for (int k = 0; k < VL; k++) mdl[(v_wi & 15)*VL + k] = v_wd[k*W +: W];
    if (d_we && d_wi[0] == 1'b0 && d_wi != 6'd63) begin
      mdl[d_wi]     = d_wd[63:32];
      mdl[d_wi + 1] = d_wd[31:0];
    end
    if (s_we) mdl[s_wi] = s_wd;
    @(posedge clk);
    @(negedge clk);
    s_we = 1'b0; d_we = 1'b0; v_we = 1'b0; m_we = 1'b0;
  endtask

  task automatic wr_s(int idx, logic [31:0] d);
    s_we = 1'b1; s_wi = 6'(idx); s_wd = d; commit();
  endtask

  task automatic wr_d(int idx, logic [63:0] d, string r);
    d_we = 1'b1; d_wi = 6'(idx); d_wd = d;
    push(5, 512'(((idx % 2) != 0 || idx == NW - 1) ? 1 : 0), r); fire();
    commit();
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state across all views
    for (int b = 0; b < 4; b++) rd_m(b, "R1");
    rd_s(63, "R1");
    rd_d(0, "R1");

    // R2: single writes, various words and patterns
    wr_s(0, 32'hDEAD_BEEF);
    wr_s(63, 32'h8000_0001);
    wr_s(17, 32'h1234_5678);
    rd_s(0, "R2"); rd_s(63, "R2"); rd_s(17, "R2"); rd_s(16, "R2");
    rd_m(1, "R2");

    // R4: pair write splits high to n, low to n+1
    wr_d(10, 64'hAAAA_0001_BBBB_0002, "R4");
    rd_s(10, "R4"); rd_s(11, "R4");
    // R3: pair read order
    rd_d(10, "R3"); rd_d(16, "R3");

    // R5: illegal pair indices
    wr_d(13, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    rd_m(0, "R5");
    wr_d(63, 64'h0123_4567_89AB_CDEF, "R5");
    rd_m(3, "R5");
    rd_d(63, "R5"); rd_d(5, "R5");

    // R6: vector masking and element order
    v_we = 1'b1; v_wi = 6'h25;
    v_wd = {32'h4444_0003, 32'h3333_0002, 32'h2222_0001, 32'h1111_0000};
    commit();
    rd_v(5, "R6"); rd_v(6'h35, "R6"); rd_s(21, "R6"); rd_s(20, "R6");

    // R7: matrix masking and element order
    m_we = 1'b1; m_wi = 6'h3E;
    for (int k = 0; k < ML; k++) m_wd[k*W +: W] = 32'hC0DE_0000 + 32'(k);
    commit();
    rd_m(2, "R7"); rd_m(6'h2A, "R7"); rd_s(47, "R7"); rd_s(32, "R7");

    // R8: all four ports onto overlapping words in one cycle
    m_we = 1'b1; m_wi = 6'd0;
    for (int k = 0; k < ML; k++) m_wd[k*W +: W] = 32'h6D00_0000 + 32'(k);
    v_we = 1'b1; v_wi = 6'd0; v_wd = {4{32'h7600_0000}};
    d_we = 1'b1; d_wi = 6'd2; d_wd = {32'h6400_00AA, 32'h6400_00BB};
    s_we = 1'b1; s_wi = 6'd3; s_wd = 32'h7300_0033;
    commit();
    rd_m(0, "R8"); rd_s(3, "R8"); rd_s(2, "R8"); rd_s(1, "R8"); rd_s(4, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule